// File: doc/BRIEF.md
# Real-Time Clock Seconds Counter with Alarm

This block keeps wall-clock time as a plain count of seconds. It runs from a slow timebase of roughly 32 kHz. A reloadable prescaler divides that clock down to one tick per second, and each tick advances a 32-bit seconds count. The same tick is compared against a 32-bit alarm value. Two sticky event flags are kept: a once-per-second flag and an alarm flag. Each flag has its own interrupt enable, and the two requests are merged onto a single interrupt line.

Software reaches the block through a simple register port: an address, a write strobe, write data and combinational read data. Every write must wait for the write-ready status bit. After a write is accepted, the block keeps that bit low for a fixed number of cycles, and any write presented during that window is dropped. A scratchpad word lets software mark the stored time as valid.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, the control word reads 0x80 (write-ready set, every other bit clear). The seconds, alarm and scratchpad registers read 0, the regulator reads RESET_REGULATOR, and irqOut is low.
- R2: The registers sit at these offsets: control 0x00, seconds 0x04, alarm 0x08, regulator 0x0C, scratchpad 0x34. The scratchpad stores any 32-bit value. Reads from any other offset return 0, and writes to other offsets change nothing.
- R3: While the counter-enable bit (control bit 0) is set, a tick occurs once every regulator+1 clock cycles. Each tick adds one to the seconds register, which wraps from 0xFFFFFFFF to 0.
- R4: While control bit 0 is clear, the prescaler and the seconds register hold their values.
- R5: Writing the regulator restarts the prescaler from zero. The first tick after that write comes regulator+1 cycles after the write edge.
- R6: Every tick sets the 1 Hz flag (control bit 6).
- R7: The alarm flag (control bit 4) sets on a tick that makes the seconds value equal to the alarm register. This happens only if alarm enable (control bit 2) was set before that edge.
- R8: Writing 1 to a flag bit leaves it unchanged, and writing 0 clears it. If an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R9: irqOut equals (bit 6 AND bit 5) OR (bit 4 AND bit 3), where bit 5 is the 1 Hz interrupt enable and bit 3 is the alarm interrupt enable.
- R10: An accepted write drives write-ready (control bit 7) low for exactly BUSY_CYCLES cycles. Writes presented while it is low are ignored, and bit 7 of the written control data has no effect.
- R11: If software writes the seconds register in the same cycle as a tick, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | slow timebase clock |
| rstN | input | 1 | active-low synchronous reset |
| busAddr | input | 8 | register byte offset |
| busWrEn | input | 1 | write strobe, accepted only while write-ready is set |
| busWrData | input | 32 | write data |
| busRdData | output | 32 | read data for busAddr (combinational) |
| irqOut | output | 1 | merged interrupt request |

## Verification
The bench builds the block with BUSY_CYCLES=2 and RESET_REGULATOR=5, then reprograms the regulator to 3 so that a tick falls every four cycles. At that rate, the seconds wrap, alarm matches, and ticks that coincide with a seconds write or a flag clear all occur within a few hundred cycles. Writes are issued at every phase of the four-cycle prescaler period, so each collision case happens at least once. The busy window is short enough that writes rejected during it can be interleaved with accepted ones.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SEC     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_ALARM   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_REG     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SCRATCH = 8'h34;

  localparam int B_READY    = 7;
  localparam int B_HZFLAG   = 6;
  localparam int B_HZIRQ    = 5;
  localparam int B_ALFLAG   = 4;
  localparam int B_ALIRQ    = 3;
  localparam int B_ALEN     = 2;
  localparam int B_CNTEN    = 0;

  typedef struct packed {
    logic wrCtrl;
    logic wrSec;
    logic wrAlarm;
    logic wrReg;
    logic wrScratch;
  } rtcStrobe_t;

  typedef struct packed {
    logic              hzFlag;
    logic              hzIrqEn;
    logic              alarmFlag;
    logic              alarmIrqEn;
    logic              alarmEn;
    logic              cntEn;
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] alarm;
    logic [DATA_W-1:0] regulator;
    logic [DATA_W-1:0] scratch;
  } rtcView_t;
endpackage

// File: rtl/rtc_sec_ctrl.sv
module rtc_sec_ctrl
  import rtc_sec_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  rtcView_t          view,
  output rtcStrobe_t        strobe,
  output logic              writeReady,
  output logic [DATA_W-1:0] rdData
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);

  logic [BW-1:0] busyCnt;
  logic          accept;

  assign writeReady = (busyCnt == '0);
  assign accept     = busWrEn && writeReady;

  always_ff @(posedge clk) begin
    if (!rstN)           busyCnt <= '0;
    else if (accept)     busyCnt <= BUSY_LOAD;
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end

  always_comb begin
    strobe.wrCtrl    = accept && (busAddr == OFF_CTRL);
    strobe.wrSec     = accept && (busAddr == OFF_SEC);
    strobe.wrAlarm   = accept && (busAddr == OFF_ALARM);
    strobe.wrReg     = accept && (busAddr == OFF_REG);
    strobe.wrScratch = accept && (busAddr == OFF_SCRATCH);
  end

  logic [DATA_W-1:0] ctrlWord;
  always_comb begin
    ctrlWord           = '0;
    ctrlWord[B_READY]  = writeReady;
    ctrlWord[B_HZFLAG] = view.hzFlag;
    ctrlWord[B_HZIRQ]  = view.hzIrqEn;
    ctrlWord[B_ALFLAG] = view.alarmFlag;
    ctrlWord[B_ALIRQ]  = view.alarmIrqEn;
    ctrlWord[B_ALEN]   = view.alarmEn;
    ctrlWord[B_CNTEN]  = view.cntEn;
  end

  always_comb begin
    case (busAddr)
      OFF_CTRL:    rdData = ctrlWord;
      OFF_SEC:     rdData = view.sec;
      OFF_ALARM:   rdData = view.alarm;
      OFF_REG:     rdData = view.regulator;
      OFF_SCRATCH: rdData = view.scratch;
      default:     rdData = '0;
    endcase
  end

  // R10: an accepted write closes the write window on the next cycle
  p_busy_after_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && writeReady) |=> !writeReady);
endmodule

// File: rtl/rtc_sec_dp.sv
module rtc_sec_dp
  import rtc_sec_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_REGULATOR = 32'd32767
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output rtcView_t          view
);
  logic [DATA_W-1:0] preCnt;
  logic [DATA_W-1:0] secNext;
  logic              tick;
  logic              alarmHit;

  assign tick     = view.cntEn && (preCnt == view.regulator);
  assign secNext  = view.sec + 1'b1;
  assign alarmHit = tick && view.alarmEn && (secNext == view.alarm);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt          <= '0;
      view.hzFlag     <= 1'b0;
      view.hzIrqEn    <= 1'b0;
      view.alarmFlag  <= 1'b0;
      view.alarmIrqEn <= 1'b0;
      view.alarmEn    <= 1'b0;
      view.cntEn      <= 1'b0;
      view.sec        <= '0;
      view.alarm      <= '0;
      view.regulator  <= RESET_REGULATOR;
      view.scratch    <= '0;
    end else begin
      // prescaler: restart on regulator write, otherwise count while enabled
      if (strobe.wrReg) begin
        view.regulator <= wrData;
        preCnt         <= '0;
      end else if (view.cntEn) begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
      end

      // seconds: a software write wins over the tick
      if (strobe.wrSec)  view.sec <= wrData;
      else if (tick)     view.sec <= secNext;

      if (strobe.wrAlarm)   view.alarm   <= wrData;
      if (strobe.wrScratch) view.scratch <= wrData;

      // flags: written 0 clears, written 1 keeps, an event sets
      view.hzFlag <= (strobe.wrCtrl ? (view.hzFlag & wrData[B_HZFLAG])
                                    : view.hzFlag) | tick;
      view.alarmFlag <= (strobe.wrCtrl ? (view.alarmFlag & wrData[B_ALFLAG])
                                       : view.alarmFlag) | alarmHit;

      if (strobe.wrCtrl) begin
        view.hzIrqEn    <= wrData[B_HZIRQ];
        view.alarmIrqEn <= wrData[B_ALIRQ];
        view.alarmEn    <= wrData[B_ALEN];
        view.cntEn      <= wrData[B_CNTEN];
      end
    end
  end

  // R3: a tick with no seconds write advances by exactly one
  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.wrSec) |=> (view.sec == $past(view.sec) + 1'b1));

  // R4: a stopped counter keeps its value
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!view.cntEn && !strobe.wrSec) |=> $stable(view.sec));

  // R8: a set 1 Hz flag stays set unless the control word is written
  p_hz_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (view.hzFlag && !strobe.wrCtrl) |=> view.hzFlag);

  // R7: with the alarm disabled the alarm flag cannot rise
  p_alarm_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!view.alarmFlag && !view.alarmEn) |=> !view.alarmFlag);
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_sec_pkg::*;
#(
  parameter int                BUSY_CYCLES     = 4,
  parameter logic [DATA_W-1:0] RESET_REGULATOR = 32'd32767
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  rtcStrobe_t strobe;
  rtcView_t   view;
  logic       writeReady;

  rtc_sec_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .view       (view),
    .strobe     (strobe),
    .writeReady (writeReady),
    .rdData     (busRdData)
  );

  rtc_sec_dp #(.RESET_REGULATOR(RESET_REGULATOR)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (busWrData),
    .view   (view)
  );

  assign irqOut = (view.hzFlag & view.hzIrqEn) | (view.alarmFlag & view.alarmIrqEn);

  // R9: with both interrupt enables clear the line stays low
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!view.hzIrqEn && !view.alarmIrqEn) |-> !irqOut);
endmodule

// File: tb/test_rtc_sec_core.sv
module test_rtc_sec_core;
  localparam int          BUSY  = 2;
  localparam logic [31:0] RSTRG = 32'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wrEn = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdData;
  logic        irq;

  always #5 clk = ~clk;

  rtc_sec_core #(.BUSY_CYCLES(BUSY), .RESET_REGULATOR(RSTRG)) i_rtc_sec_core (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWrEn(wrEn),
    .busWrData(wdata), .busRdData(rdData), .irqOut(irq)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string curTag = "R1";

  // behavioural reference state
  logic [31:0] mSec, mAlarm, mReg, mScr, mPre;
  bit          mHz, mHzIe, mAf, mAfIe, mAen, mEn;
  int          mBusy;

  always @(posedge clk) begin
    bit          acc, tk, hit;
    logic [31:0] nx;
    if (!rstN) begin
      mSec = 0; mAlarm = 0; mReg = RSTRG; mScr = 0; mPre = 0;
      mHz = 0; mHzIe = 0; mAf = 0; mAfIe = 0; mAen = 0; mEn = 0; mBusy = 0;
    end else begin
      acc = wrEn && (mBusy == 0);
      tk  = mEn && (mPre == mReg);
      nx  = mSec + 1;
      hit = tk && mAen && (nx == mAlarm);
      if (mEn) mPre = tk ? 0 : mPre + 1;
      if (acc && addr == 8'h00) begin
        mHz = mHz & wdata[6]; mAf = mAf & wdata[4];
        mHzIe = wdata[5]; mAfIe = wdata[3]; mAen = wdata[2]; mEn = wdata[0];
      end
      if (tk) mHz = 1;
      if (hit) mAf = 1;
      if (acc && addr == 8'h04) mSec = wdata;
      else if (tk) mSec = nx;
      if (acc && addr == 8'h08) mAlarm = wdata;
      if (acc && addr == 8'h0C) begin mReg = wdata; mPre = 0; end
      if (acc && addr == 8'h34) mScr = wdata;
      if (acc) mBusy = BUSY;
      else if (mBusy > 0) mBusy = mBusy - 1;
    end
  end

  function automatic logic [31:0] expRd(input logic [7:0] a);
    case (a)
      8'h00: return {24'd0, mBusy == 0, mHz, mHzIe, mAf, mAfIe, mAen, 1'b0, mEn};
      8'h04: return mSec;
      8'h08: return mAlarm;
      8'h0C: return mReg;
      8'h34: return mScr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curTag, " rd"}, rdData, expRd(addr));
      check({"R9 irq"}, {31'd0, irq}, {31'd0, (mHz & mHzIe) | (mAf & mAfIe)});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic look(input logic [7:0] a);
    @(negedge clk); #1 addr = a;
  endtask

  // waits for write-ready from the model, then issues one write
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    while (mBusy != 0) @(negedge clk);
    #1 addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    idle(3);
    #1 rstN = 1'b1;
    // R1 reset state
    curTag = "R1";
    look(8'h00); #2 check("R1 ctrl", rdData, 32'h80);
    check("R1 irq", {31'd0, irq}, 32'd0);
    look(8'h04); #2 check("R1 sec", rdData, 32'd0);
    look(8'h08); #2 check("R1 alarm", rdData, 32'd0);
    look(8'h0C); #2 check("R1 regulator", rdData, RSTRG);
    look(8'h34); #2 check("R1 scratch", rdData, 32'd0);

    // R2 scratchpad and unmapped offsets
    curTag = "R2";
    wr(8'h34, 32'hA5C3_0F96); look(8'h34); #2 check("R2 scratch", rdData, 32'hA5C3_0F96);
    wr(8'h40, 32'hFFFF_FFFF); look(8'h40); #2 check("R2 unmapped", rdData, 32'd0);
    look(8'h34); #2 check("R2 scratch kept", rdData, 32'hA5C3_0F96);

    // R10 busy window: second write dropped, bit 7 of data ignored
    curTag = "R10";
    wr(8'h08, 32'd77);
    #1 addr = 8'h04; wdata = 32'd1234; wrEn = 1'b1;
    @(negedge clk); #1 wrEn = 1'b0;
    look(8'h04); #2 check("R10 write while busy ignored", rdData, 32'd0);
    look(8'h00); #2 check("R10 ready back", rdData, 32'h80);
    wr(8'h00, 32'h80);
    #2 check("R10 ready low after write", rdData & 32'h80, 32'h00);

    // R5 / R3 reprogram regulator and run
    curTag = "R5";
    wr(8'h0C, 32'd3);
    wr(8'h00, 32'h01);
    look(8'h04); idle(30);
    curTag = "R3";
    look(8'h00); idle(10);
    // R6 flag seen, R8 writing 1 keeps it
    curTag = "R6";
    check("R6 hz flag set", rdData & 32'h40, 32'h40);
    curTag = "R8";
    for (int ph = 0; ph < 5; ph++) begin
      wr(8'h00, 32'h41); look(8'h00); idle(ph);
      wr(8'h00, 32'h01); look(8'h00); idle(3);
    end

    // R11 seconds write at every prescaler phase, including a wrap
    curTag = "R11";
    for (int ph = 0; ph < 5; ph++) begin
      wr(8'h04, 32'hFFFF_FFFE); look(8'h04); idle(ph + 5);
    end
    curTag = "R3";
    look(8'h04); idle(12);

    // R7 alarm with enable, then gated off
    curTag = "R7";
    wr(8'h04, 32'd100);
    wr(8'h08, 32'd103);
    wr(8'h00, 32'h2D);
    look(8'h00); idle(24);
    check("R7 alarm flag set", rdData & 32'h10, 32'h10);
    curTag = "R9";
    check("R9 irq high", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'h01);
    curTag = "R7";
    wr(8'h04, 32'd200);
    wr(8'h08, 32'd202);
    look(8'h00); idle(20);
    check("R7 alarm gated", rdData & 32'h10, 32'h00);
    curTag = "R9";
    wr(8'h00, 32'h21); look(8'h00); idle(10);

    // R4 stop the counter
    curTag = "R4";
    wr(8'h00, 32'h00);
    look(8'h04); idle(2);
    begin
      logic [31:0] held;
      held = rdData;
      idle(20);
      check("R4 seconds held", rdData, held);
    end
    // R5 restart: regulator write then enable, tick spacing from model
    curTag = "R5";
    wr(8'h0C, 32'd6); wr(8'h00, 32'h01); look(8'h04); idle(30);

    idle(2);
    finishRun();
  end
endmodule